// File: doc/BRIEF.md
# SPI Slave Frame Validator

This block is an SPI slave in mode 0. It receives a frame that begins with a length byte N and continues with N payload bytes. The master then clocks one more byte inside the same chip-select window. While that byte is clocked, the slave returns a verdict on MISO. The verdict is worked out from the bytes already received, during the gap between the final payload bit and the first shift of the response byte. No software has to preload it. A frame is valid when N lies between 1 and the parameter `MAX_LEN` and the XOR of the length byte and every payload byte is zero. In a valid frame the last payload byte therefore serves as a check byte.

The block runs on a system clock that is at least 8 times the SCLK rate. SCLK, MOSI and CS_N each pass through a synchronizer chain before any edge detection. Each received byte is presented on a valid-only stream, `rx_valid`/`rx_data`. This stream has no ready input because the SPI master sets the pace and cannot be stalled. A consumer must take every byte in the cycle where `rx_valid` is high, and each pulse lasts exactly one cycle. A separate one-cycle `done_valid` pulse reports the outcome of each chip-select window on `done_status`.

Top module: `spi_frame_checker`

## Requirements
- R1: MOSI is sampled on rising SCLK, MSB first. After every complete byte (length, payload and response slot), `rx_data` carries that byte together with a one-cycle `rx_valid` pulse.
- R2: During the length and payload bytes MISO sends 0x00, MSB first, and changes only after falling SCLK. MISO is 0 while CS_N is high.
- R3: With 1 <= N <= MAX_LEN and a zero XOR over the length and payload bytes, the response byte is 0xA5 and `done_status` is 0 (accepted).
- R4: With N = 0 or N > MAX_LEN, the response byte is 0x5A and `done_status` is 1 (bad length). The slave still counts N payload bytes before the response byte, and a bad length takes precedence over a bad XOR.
- R5: With a legal N but a non-zero XOR, the response byte is 0x5A and `done_status` is 2 (bad check).
- R6: SCLK may stop for any time between the last payload byte and the response byte while CS_N stays low, and the response is unaffected.
- R7: If CS_N rises before the response byte has been fully clocked, one `done_valid` pulse is raised with `done_status` 3 (aborted). The next CS_N fall then starts a new frame from its length byte.
- R8: After the response byte, further bytes read 0xFF on MISO and raise neither `rx_valid` nor `done_valid` until CS_N rises.
- R9: Each chip-select window that contains at least a CS_N fall produces exactly one `done_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from master, idles low |
| spi_mosi | input | 1 | Serial data from master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to master |
| rx_valid | output | 1 | One-cycle strobe, a byte has been received |
| rx_data | output | 8 | Received byte, valid with rx_valid |
| done_valid | output | 1 | One-cycle strobe at the end of a frame |
| done_status | output | 2 | 0 accepted, 1 bad length, 2 bad check, 3 aborted |

## Verification
The hardest case to reach is a response byte whose first bit must already be on MISO while SCLK is stalled after the final payload byte. A late verdict would show up only in the MSB of the response. The bench drives SCLK edges directly, so it can insert a long pause at exactly that byte boundary on some frames and omit it on others. It also raises CS_N partway through a byte and partway through the response byte, which exercises abort handling from every phase. Finally, it sweeps every length from 0 past `MAX_LEN`, with both good and corrupted check bytes.

// File: rtl/spifc_pkg.sv
package spifc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_ACK  = 8'hA5;
  localparam logic [BYTE_W-1:0] CODE_NACK = 8'h5A;
  localparam logic [BYTE_W-1:0] CODE_FILL = 8'h00;
  localparam logic [BYTE_W-1:0] CODE_TAIL = 8'hFF;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BAD_LEN = 2'd1,
    ST_BAD_SUM = 2'd2,
    ST_ABORT   = 2'd3
  } spifc_status_e;

  typedef enum logic [1:0] {
    PH_LEN  = 2'd0,
    PH_PAY  = 2'd1,
    PH_RESP = 2'd2,
    PH_TAIL = 2'd3
  } spifc_phase_e;
endpackage

// File: rtl/spifc_sync.sv
module spifc_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spifc_bitio.sv
module spifc_bitio
  import spifc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cs_n_s,
  input  logic [BYTE_W-1:0] tx_next,
  output logic              cs_start,
  output logic              cs_end,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_q,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sclk_d, cs_n_d, load_pend;
  logic              rise, fall, cs_act;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr;

  assign cs_act   = ~cs_n_s;
  assign rise     = cs_act & sclk_s & ~sclk_d;
  assign fall     = cs_act & ~sclk_s & sclk_d;
  assign cs_start = ~cs_n_s & cs_n_d;
  assign cs_end   = cs_n_s & ~cs_n_d;
  assign miso     = cs_act & tx_sr[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      cs_n_d    <= 1'b1;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= CODE_FILL;
      load_pend <= 1'b0;
      byte_done <= 1'b0;
      byte_q    <= '0;
    end else begin
      sclk_d    <= sclk_s;
      cs_n_d    <= cs_n_s;
      byte_done <= 1'b0;
      if (cs_start) begin
        bit_cnt   <= '0;
        tx_sr     <= CODE_FILL;
        load_pend <= 1'b0;
      end else begin
        if (rise) begin
          rx_sr   <= {rx_sr[BYTE_W-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
            byte_done <= 1'b1;
            byte_q    <= {rx_sr[BYTE_W-2:0], mosi_s};
            load_pend <= 1'b1;
          end
        end
        if (fall) begin
          if (load_pend) begin
            tx_sr     <= tx_next;
            load_pend <= 1'b0;
          end else begin
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spifc_frame.sv
module spifc_frame
  import spifc_pkg::*;
#(
  parameter int MAX_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_start,
  input  logic              cs_end,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] tx_next,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              done_valid,
  output logic [1:0]        done_status
);
  localparam logic [BYTE_W-1:0] MAX_B = BYTE_W'(MAX_LEN);

  spifc_phase_e      phase;
  spifc_status_e     verdict, verdict_n;
  logic [BYTE_W-1:0] len_q, cnt_q, xor_q, xor_n;
  logic              bad_len;

  assign xor_n = xor_q ^ byte_in;

  always_comb begin
    if (bad_len)              verdict_n = ST_BAD_LEN;
    else if (xor_n != '0)     verdict_n = ST_BAD_SUM;
    else                      verdict_n = ST_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_LEN;
      verdict     <= ST_OK;
      len_q       <= '0;
      cnt_q       <= '0;
      xor_q       <= '0;
      bad_len     <= 1'b0;
      tx_next     <= CODE_FILL;
      rx_valid    <= 1'b0;
      rx_data     <= '0;
      done_valid  <= 1'b0;
      done_status <= ST_OK;
    end else begin
      rx_valid   <= 1'b0;
      done_valid <= 1'b0;
      if (cs_start || cs_end) begin
        if (cs_end && phase != PH_TAIL) begin
          done_valid  <= 1'b1;
          done_status <= ST_ABORT;
        end
        phase   <= PH_LEN;
        cnt_q   <= '0;
        xor_q   <= '0;
        bad_len <= 1'b0;
        tx_next <= CODE_FILL;
      end else if (byte_done) begin
        unique case (phase)
          PH_LEN: begin
            rx_valid <= 1'b1;
            rx_data  <= byte_in;
            len_q    <= byte_in;
            xor_q    <= byte_in;
            cnt_q    <= '0;
            if (byte_in == '0) begin
              phase   <= PH_RESP;
              verdict <= ST_BAD_LEN;
              tx_next <= CODE_NACK;
            end else begin
              phase   <= PH_PAY;
              bad_len <= (byte_in > MAX_B);
              tx_next <= CODE_FILL;
            end
          end
          PH_PAY: begin
            rx_valid <= 1'b1;
            rx_data  <= byte_in;
            xor_q    <= xor_n;
            if (cnt_q == len_q - 1'b1) begin
              phase   <= PH_RESP;
              verdict <= verdict_n;
              tx_next <= (verdict_n == ST_OK) ? CODE_ACK : CODE_NACK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_RESP: begin
            rx_valid    <= 1'b1;
            rx_data     <= byte_in;
            done_valid  <= 1'b1;
            done_status <= verdict;
            phase       <= PH_TAIL;
            tx_next     <= CODE_TAIL;
          end
          PH_TAIL: ;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_frame_checker.sv
module spi_frame_checker
  import spifc_pkg::*;
#(
  parameter int MAX_LEN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              done_valid,
  output logic [1:0]        done_status
);
  logic [2:0]        pins_s;
  logic              cs_start, cs_end, byte_done;
  logic [BYTE_W-1:0] byte_q, tx_next;

  spifc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_mosi, spi_sclk}),
    .q     (pins_s)
  );

  spifc_bitio u_bitio (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[0]),
    .mosi_s    (pins_s[1]),
    .cs_n_s    (pins_s[2]),
    .tx_next   (tx_next),
    .cs_start  (cs_start),
    .cs_end    (cs_end),
    .byte_done (byte_done),
    .byte_q    (byte_q),
    .miso      (spi_miso)
  );

  spifc_frame #(.MAX_LEN(MAX_LEN)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_start    (cs_start),
    .cs_end      (cs_end),
    .byte_done   (byte_done),
    .byte_in     (byte_q),
    .tx_next     (tx_next),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .done_valid  (done_valid),
    .done_status (done_status)
  );
endmodule

// File: rtl/spifc_chk.sv
module spifc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso,
  input logic       rx_valid,
  input logic       done_valid,
  input logic [1:0] done_status
);
  logic [2:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 1'b1;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R1
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R2
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3'd7 && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) &&
     $past(spi_cs_n, 3) && $past(spi_cs_n, 4)) |-> !spi_miso);

  // R7
  abort_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd3 && done_valid && done_status == 2'd3) |-> $past(spi_cs_n, 2));

  // R8
  resp_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_status != 2'd3) |-> rx_valid);
endmodule

bind spi_frame_checker spifc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_cs_n    (spi_cs_n),
  .spi_miso    (spi_miso),
  .rx_valid    (rx_valid),
  .done_valid  (done_valid),
  .done_status (done_status)
);

// File: tb/spi_frame_checker_tb_top.sv
module spi_frame_checker_tb_top;
  localparam int MAX_LEN = 8;
  localparam int HALF    = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0;
  logic       spi_mosi = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_miso;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       done_valid;
  logic [1:0] done_status;

  int n_chk = 0;
  int n_fail = 0;
  int rx_n = 0;
  int done_n = 0;
  logic [1:0] last_st = 2'd0;
  logic [7:0] rx_log [64];
  logic [7:0] fb [64];

  always #2 clk = ~clk;

  spi_frame_checker #(.MAX_LEN(MAX_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .rx_valid(rx_valid),
    .rx_data(rx_data), .done_valid(done_valid), .done_status(done_status)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      if (rx_n < 64) rx_log[rx_n] = rx_data;
      rx_n = rx_n + 1;
    end
    if (done_valid) begin
      done_n  = done_n + 1;
      last_st = done_status;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = tx[i];
      wclk(HALF);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      wclk(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  // Full frame: len byte, payload, optional pause, response slot, extra bytes
  task automatic run_frame(input int len, input bit corrupt, input bit pause, input int extra);
    logic [7:0] rx, x;
    int exp_st;
    bit zero_ok;
    x = 8'(len);
    for (int i = 0; i < len - 1; i++) begin
      fb[i] = 8'((len * 37 + i * 11 + 5) & 8'hFF);
      x = x ^ fb[i];
    end
    if (len > 0) fb[len-1] = corrupt ? (x ^ 8'h10) : x;
    if (len == 0 || len > MAX_LEN) exp_st = 1;
    else if (corrupt)              exp_st = 2;
    else                           exp_st = 0;
    rx_n = 0; done_n = 0; zero_ok = 1;
    spi_cs_n = 1'b0;
    wclk(HALF);
    xfer(8'(len), 8, rx);
    if (rx != 8'h00) zero_ok = 0;
    for (int i = 0; i < len; i++) begin
      xfer(fb[i], 8, rx);
      if (rx != 8'h00) zero_ok = 0;
    end
    // R2: length and payload slots read zero
    chk(zero_ok, "R2 fill bytes", zero_ok, 1);
    if (pause) wclk(400);
    xfer(8'h3C, 8, rx);
    // R3 / R4 / R5: response code
    chk(rx == ((exp_st == 0) ? 8'hA5 : 8'h5A),
        (exp_st == 0) ? "R3 resp" : ((exp_st == 1) ? "R4 resp" : "R5 resp"),
        rx, (exp_st == 0) ? 8'hA5 : 8'h5A);
    if (pause) chk(rx == ((exp_st == 0) ? 8'hA5 : 8'h5A), "R6 resp after pause", rx,
                   (exp_st == 0) ? 8'hA5 : 8'h5A);
    for (int e = 0; e < extra; e++) begin
      xfer(8'h81, 8, rx);
      // R8: tail bytes
      chk(rx == 8'hFF, "R8 tail byte", rx, 8'hFF);
    end
    wclk(HALF);
    spi_cs_n = 1'b1;
    wclk(3 * HALF);
    // R1: received byte stream
    chk(rx_n == len + 2, "R1 rx count", rx_n, len + 2);
    if (rx_n == len + 2 && len + 2 <= 64) begin
      bit same = (rx_log[0] == 8'(len)) && (rx_log[len+1] == 8'h3C);
      for (int i = 0; i < len; i++) if (rx_log[i+1] != fb[i]) same = 0;
      chk(same, "R1 rx data", same, 1);
    end
    chk(done_n == 1, "R9 done count", done_n, 1);
    chk(int'(last_st) == exp_st, "R3/R4/R5 status", last_st, exp_st);
  endtask

  task automatic run_abort(input int len, input int bytes_sent, input int bits_last);
    logic [7:0] rx;
    rx_n = 0; done_n = 0;
    spi_cs_n = 1'b0;
    wclk(HALF);
    if (bytes_sent > 0) xfer(8'(len), 8, rx);
    for (int i = 1; i < bytes_sent; i++) xfer(8'h55, 8, rx);
    if (bits_last > 0) xfer(8'hF0, bits_last, rx);
    wclk(HALF);
    spi_cs_n = 1'b1;
    wclk(3 * HALF);
    // R7: aborted window
    chk(done_n == 1, "R7 abort done count", done_n, 1);
    chk(last_st == 2'd3, "R7 abort status", last_st, 3);
    chk(rx_n == bytes_sent, "R7 abort rx count", rx_n, bytes_sent);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(10);
    // R2 / R9: reset state
    chk(spi_miso == 1'b0, "R2 reset miso", spi_miso, 0);
    chk(rx_n == 0 && done_n == 0, "R9 reset strobes", rx_n + done_n, 0);

    for (int len = 0; len <= MAX_LEN + 2; len++) begin
      run_frame(len, 1'b0, (len % 2) == 1, len % 3);
      run_frame(len, 1'b1, (len % 2) == 0, 1);
    end
    run_frame(40, 1'b0, 1'b1, 2);

    run_abort(0, 0, 0);
    run_frame(3, 1'b0, 1'b0, 0);
    run_abort(4, 3, 0);
    run_frame(MAX_LEN, 1'b0, 1'b1, 1);
    run_abort(2, 1, 5);
    run_frame(1, 1'b0, 1'b0, 0);
    run_abort(2, 3, 4);
    run_frame(2, 1'b0, 1'b1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule